// File: doc/BRIEF.md
# Serial Memory Status Register and Write Guard

This block keeps the 8-bit status register of a small serial nonvolatile memory and decides, for every decoded write request, whether that write may go ahead. It joins four sources of protection: a 3-bit protection code that fences off part of the 2 KiB array, a write-enable latch that must be armed before any write, a lock bit in the status register, and the external write-protect pin. Opcode decoding and the timing of the nonvolatile cells are handled elsewhere. The block receives decoded request pulses, the target address, the chip-select and write-protect pins, and a busy flag from the write engine.

A request raises a permit level for the current chip-select frame. When chip select returns high while a permit is held, the block issues a one-cycle start pulse to the write engine. For a status write it also commits the new lock bit and protection code at that same edge. The write-enable latch clears once the engine's busy flag has risen and fallen again after that start. A pending status write is cancelled if the protect pin falls while the frame is still open and the lock bit is set.

Top module: `nvm_status_guard`

## Requirements
- R1: `status` reads {lock bit, 1, 1, protection code[2:0], write-enable latch, ready}, with bit 7 the lock bit and bit 0 the ready bit. Ready equals `busy` as sampled one cycle earlier, with 1 meaning a write cycle is running. After synchronous reset `status` reads 8'h60.
- R2: Protection codes 3'b001, 3'b010, 3'b011 and 3'b100 each fence one quarter of the array: 0x000-0x1FF, 0x200-0x3FF, 0x400-0x5FF and 0x600-0x7FF respectively. Code 3'b000 fences nothing.
- R3: Code 3'b101 fences 0x000-0x3FF, code 3'b110 fences 0x000-0x01F and code 3'b111 fences 0x7E0-0x7FF. An array request to a fenced address never gets a permit.
- R4: While the write-enable latch is 0, neither array nor status requests get a permit, whatever the lock bit and pin.
- R5: With the latch set and either the lock bit clear or `wprot_n` high, status requests and array requests to unfenced addresses get a permit one cycle after the request.
- R6: With the latch set, the lock bit set and `wprot_n` low, status requests are refused, while array requests to unfenced addresses are still permitted.
- R7: If `wprot_n` goes low while chip select is low, a status permit is held and the lock bit is set, the permit drops on the next cycle. That status write then never starts and leaves the register unchanged.
- R8: Once a status write has started, `wprot_n` has no effect on it: the new lock bit and code stay committed.
- R9: On the edge where `cs_n` is first sampled high after being low, a held permit produces a one-cycle `wr_start` pulse. A status permit also commits `sr_wdata[7]` to the lock bit and `sr_wdata[4:2]` to the code at that edge. The other data bits are ignored.
- R10: The write-enable latch is set by `wel_set` when not busy and cleared by `wel_clr`. It also clears by itself when `busy` falls after having risen following a `wr_start`.
- R11: Requests made while `busy` is high get no permit. Every permit is cleared one cycle after `cs_n` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, low while a frame is open |
| wprot_n | input | 1 | Write-protect pin, low asserts protection |
| busy | input | 1 | Write engine busy flag |
| wel_set | input | 1 | Decoded write-enable request pulse |
| wel_clr | input | 1 | Decoded write-disable request pulse |
| arr_req | input | 1 | Decoded array write request pulse |
| arr_addr | input | ADDR_W | Target address of the array write |
| sr_req | input | 1 | Decoded status write request pulse |
| sr_wdata | input | 8 | Data byte of the status write |
| arr_permit | output | 1 | Array write in this frame is allowed |
| sr_permit | output | 1 | Status write in this frame is allowed |
| wr_start | output | 1 | One-cycle start of a permitted write cycle |
| status | output | 8 | Status register contents |

## Verification
The assertions assume several things about the inputs. Request pulses arrive only while `cs_n` is low. At most one kind of write request is open in a frame. The `wprot_n` pin is already synchronous to `clk`. `busy` rises only after a `wr_start`, apart from deliberate busy-time requests. The stimulus keeps to these rules: every frame is opened before its pulses and closed after them, and busy is raised only after a start or for the dedicated refusal check. The array sweep covers every address under every protection code, and the lock checks cover every combination of latch, lock bit and pin.

// File: rtl/nvsg_pkg.sv
package nvsg_pkg;
  localparam int SR_W    = 8;
  localparam int B_LOCK  = 7;
  localparam int B_CODEH = 4;
  localparam int B_CODEL = 2;
  localparam int B_WEL   = 1;
  localparam int B_RDY   = 0;

  typedef enum logic [2:0] {
    FENCE_NONE = 3'b000,
    FENCE_Q0   = 3'b001,
    FENCE_Q1   = 3'b010,
    FENCE_Q2   = 3'b011,
    FENCE_Q3   = 3'b100,
    FENCE_LOW  = 3'b101,
    FENCE_HEAD = 3'b110,
    FENCE_TAIL = 3'b111
  } fence_e;
endpackage

// File: rtl/nvsg_fence_map.sv
module nvsg_fence_map #(
  parameter int ADDR_W = 11,
  parameter int EDGE_W = 5
) (
  input  logic [2:0]        code,
  input  logic [ADDR_W-1:0] addr,
  output logic              fenced
);
  import nvsg_pkg::*;
  localparam int NQ = 4;

  logic [NQ-1:0] q_sel;
  logic          head_hit;
  logic          tail_hit;

  for (genvar gi = 0; gi < NQ; gi++) begin : g_quarter
    assign q_sel[gi] = (addr[ADDR_W-1 -: 2] == 2'(gi));
  end

  assign head_hit = (addr[ADDR_W-1:EDGE_W] == '0);
  assign tail_hit = (&addr[ADDR_W-1:EDGE_W]);

  always_comb begin
    case (code)
      FENCE_Q0:   fenced = q_sel[0];
      FENCE_Q1:   fenced = q_sel[1];
      FENCE_Q2:   fenced = q_sel[2];
      FENCE_Q3:   fenced = q_sel[3];
      FENCE_LOW:  fenced = ~addr[ADDR_W-1];
      FENCE_HEAD: fenced = head_hit;
      FENCE_TAIL: fenced = tail_hit;
      default:    fenced = 1'b0;
    endcase
  end
endmodule

// File: rtl/nvsg_frame_ctl.sv
module nvsg_frame_ctl (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic wprot_n,
  input  logic busy,
  input  logic wel,
  input  logic lock,
  input  logic arr_req,
  input  logic arr_fenced,
  input  logic sr_req,
  output logic arr_permit,
  output logic sr_permit,
  output logic wr_start,
  output logic commit_any,
  output logic commit_sr
);
  logic cs_q;
  logic cs_rise;
  logic sr_locked;

  assign cs_rise    = cs_n & ~cs_q;
  assign sr_locked  = lock & ~wprot_n;
  assign commit_any = cs_rise & (arr_permit | sr_permit);
  assign commit_sr  = cs_rise & sr_permit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q       <= 1'b1;
      arr_permit <= 1'b0;
      sr_permit  <= 1'b0;
      wr_start   <= 1'b0;
    end else begin
      cs_q     <= cs_n;
      wr_start <= commit_any;
      if (cs_n) begin
        arr_permit <= 1'b0;
        sr_permit  <= 1'b0;
      end else begin
        if (arr_req)
          arr_permit <= wel & ~busy & ~arr_fenced;
        if (sr_req)
          sr_permit <= wel & ~busy & ~sr_locked;
        else if (sr_locked)
          sr_permit <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nvsg_sreg.sv
module nvsg_sreg (
  input  logic       clk,
  input  logic       rst,
  input  logic       busy,
  input  logic       wel_set,
  input  logic       wel_clr,
  input  logic       sr_req,
  input  logic [7:0] sr_wdata,
  input  logic       commit_any,
  input  logic       commit_sr,
  output logic       wel,
  output logic       lock,
  output logic [2:0] code,
  output logic [7:0] status
);
  import nvsg_pkg::*;

  logic       busy_q;
  logic       cyc;
  logic       seen;
  logic       done;
  logic       pend_lock;
  logic [2:0] pend_code;
  logic       wdata_unused;

  assign wdata_unused = ^{sr_wdata[6:5], sr_wdata[1:0]};
  assign done         = seen & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      cyc       <= 1'b0;
      seen      <= 1'b0;
      wel       <= 1'b0;
      lock      <= 1'b0;
      code      <= '0;
      pend_lock <= 1'b0;
      pend_code <= '0;
    end else begin
      busy_q <= busy;
      if (sr_req) begin
        pend_lock <= sr_wdata[B_LOCK];
        pend_code <= sr_wdata[B_CODEH:B_CODEL];
      end
      if (commit_sr) begin
        lock <= pend_lock;
        code <= pend_code;
      end
      if (done) begin
        cyc  <= 1'b0;
        seen <= 1'b0;
      end else if (cyc & busy) begin
        seen <= 1'b1;
      end
      if (commit_any)
        cyc <= 1'b1;
      if (done)
        wel <= 1'b0;
      else if (wel_clr)
        wel <= 1'b0;
      else if (wel_set & ~busy)
        wel <= 1'b1;
    end
  end

  always_comb begin
    status         = 8'h60;
    status[B_LOCK] = lock;
    status[B_CODEH:B_CODEL] = code;
    status[B_WEL]  = wel;
    status[B_RDY]  = busy_q;
  end
endmodule

// File: rtl/nvm_status_guard.sv
module nvm_status_guard #(
  parameter int ADDR_W = 11,
  parameter int EDGE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wprot_n,
  input  logic              busy,
  input  logic              wel_set,
  input  logic              wel_clr,
  input  logic              arr_req,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic              sr_req,
  input  logic [7:0]        sr_wdata,
  output logic              arr_permit,
  output logic              sr_permit,
  output logic              wr_start,
  output logic [7:0]        status
);
  logic       wel;
  logic       lock;
  logic [2:0] code;
  logic       fenced;
  logic       commit_any;
  logic       commit_sr;

  nvsg_fence_map #(.ADDR_W(ADDR_W), .EDGE_W(EDGE_W)) u_map (
    .code   (code),
    .addr   (arr_addr),
    .fenced (fenced)
  );

  nvsg_frame_ctl u_frame (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .wprot_n    (wprot_n),
    .busy       (busy),
    .wel        (wel),
    .lock       (lock),
    .arr_req    (arr_req),
    .arr_fenced (fenced),
    .sr_req     (sr_req),
    .arr_permit (arr_permit),
    .sr_permit  (sr_permit),
    .wr_start   (wr_start),
    .commit_any (commit_any),
    .commit_sr  (commit_sr)
  );

  nvsg_sreg u_sreg (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .wel_set    (wel_set),
    .wel_clr    (wel_clr),
    .sr_req     (sr_req),
    .sr_wdata   (sr_wdata),
    .commit_any (commit_any),
    .commit_sr  (commit_sr),
    .wel        (wel),
    .lock       (lock),
    .code       (code),
    .status     (status)
  );
endmodule

// File: rtl/nvsg_chk.sv
module nvsg_chk #(
  parameter int ADDR_W = 11,
  parameter int EDGE_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              wprot_n,
  input logic              busy,
  input logic              arr_req,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              sr_req,
  input logic              arr_permit,
  input logic              sr_permit,
  input logic              wr_start,
  input logic [7:0]        status
);
  AST_FIXED_ONES: assert property (@(posedge clk) disable iff (rst)
    status[6:5] == 2'b11); // R1
  AST_RDY_TRACKS_BUSY: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (status[0] == $past(busy))); // R1
  AST_HEAD_FENCED: assert property (@(posedge clk) disable iff (rst)
    (arr_req && !cs_n && status[4:2] == 3'b110 && (arr_addr >> EDGE_W) == '0) |=> !arr_permit); // R3
  AST_NO_WEL_NO_ARR: assert property (@(posedge clk) disable iff (rst)
    (arr_req && !status[1]) |=> !arr_permit); // R4
  AST_NO_WEL_NO_SR: assert property (@(posedge clk) disable iff (rst)
    (sr_req && !status[1]) |=> !sr_permit); // R4
  AST_SR_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (sr_req && status[7] && !wprot_n) |=> !sr_permit); // R6
  AST_SR_CANCEL: assert property (@(posedge clk) disable iff (rst)
    (sr_permit && !cs_n && status[7] && !wprot_n) |=> !sr_permit); // R7
  AST_START_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (rst)
    wr_start |-> $past(arr_permit || sr_permit)); // R9
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wr_start |=> !wr_start); // R9
  AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!arr_permit && !sr_permit)); // R11
  AST_BUSY_DENY: assert property (@(posedge clk) disable iff (rst)
    (arr_req && busy) |=> !arr_permit); // R11
endmodule

bind nvm_status_guard nvsg_chk #(.ADDR_W(ADDR_W), .EDGE_W(EDGE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_n       (cs_n),
  .wprot_n    (wprot_n),
  .busy       (busy),
  .arr_req    (arr_req),
  .arr_addr   (arr_addr),
  .sr_req     (sr_req),
  .arr_permit (arr_permit),
  .sr_permit  (sr_permit),
  .wr_start   (wr_start),
  .status     (status)
);

// File: tb/nvm_status_guard_tb.sv
`timescale 1ns/100ps
module nvm_status_guard_tb;
  localparam int ADDR_W = 11;
  localparam int NADDR  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cs_n = 1'b1;
  logic              wprot_n = 1'b1;
  logic              busy = 1'b0;
  logic              wel_set = 1'b0;
  logic              wel_clr = 1'b0;
  logic              arr_req = 1'b0;
  logic [ADDR_W-1:0] arr_addr = '0;
  logic              sr_req = 1'b0;
  logic [7:0]        sr_wdata = '0;
  logic              arr_permit;
  logic              sr_permit;
  logic              wr_start;
  logic [7:0]        status;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  nvm_status_guard #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wprot_n(wprot_n), .busy(busy),
    .wel_set(wel_set), .wel_clr(wel_clr), .arr_req(arr_req), .arr_addr(arr_addr),
    .sr_req(sr_req), .sr_wdata(sr_wdata), .arr_permit(arr_permit),
    .sr_permit(sr_permit), .wr_start(wr_start), .status(status)
  );

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_fenced(input int code, input int a);
    case (code)
      1: return a < 512;
      2: return a >= 512 && a < 1024;
      3: return a >= 1024 && a < 1536;
      4: return a >= 1536;
      5: return a < 1024;
      6: return a < 32;
      7: return a >= 2016;
      default: return 1'b0;
    endcase
  endfunction

  task automatic wren;
    wel_set = 1'b1; tick; wel_set = 1'b0;
  endtask

  task automatic run_busy(input bit drop_pin);
    busy = 1'b1; tick;
    if (drop_pin) wprot_n = 1'b0;
    tick; tick;
    busy = 1'b0; tick; tick;
  endtask

  task automatic write_sr(input logic [7:0] d);
    wren;
    cs_n = 1'b0; sr_req = 1'b1; sr_wdata = d; tick;
    sr_req = 1'b0;
    chk(sr_permit == 1'b1, "R5 status permit", sr_permit, 1);
    cs_n = 1'b1; tick;
    chk(wr_start == 1'b1, "R9 start on deselect", wr_start, 1);
    run_busy(1'b0);
  endtask

  initial begin
    tick; tick; tick;
    rst = 1'b0; tick;
    chk(status == 8'h60, "R1 reset status", status, 8'h60);
    chk(!arr_permit && !sr_permit && !wr_start, "R1 reset outputs", {arr_permit, sr_permit, wr_start}, 0);

    // R4: latch clear blocks everything
    begin
      int bad = 0;
      cs_n = 1'b0;
      for (int a = 0; a < NADDR; a++) begin
        arr_req = 1'b1; arr_addr = ADDR_W'(a); tick;
        if (arr_permit) bad++;
      end
      arr_req = 1'b0;
      chk(bad == 0, "R4 array blocked without latch", bad, 0);
      sr_req = 1'b1; sr_wdata = 8'h00; tick; sr_req = 1'b0;
      chk(!sr_permit, "R4 status blocked without latch", sr_permit, 0);
      cs_n = 1'b1; tick;
      chk(!wr_start, "R4 no start", wr_start, 0);
    end

    // R2 R3: every code over every address
    for (int c = 0; c < 8; c++) begin
      int bad = 0;
      bit last_ok;
      write_sr({3'b000, 3'(c), 2'b00});
      chk(status == {3'b011, 3'(c), 2'b00}, "R9 code committed", status, {3'b011, 3'(c), 2'b00});
      wren;
      cs_n = 1'b0;
      for (int a = 0; a < NADDR; a++) begin
        arr_req = 1'b1; arr_addr = ADDR_W'(a); tick;
        if (arr_permit != !exp_fenced(c, a)) begin
          bad++;
          if (bad < 4)
            $display("FAIL R2/R3 code=%0d addr=%0h actual=%0b expected=%0b", c, a, arr_permit, !exp_fenced(c, a));
        end
      end
      arr_req = 1'b0;
      checks++;
      if (bad != 0) errors++;
      last_ok = !exp_fenced(c, NADDR - 1);
      cs_n = 1'b1; tick;
      chk(wr_start == last_ok, "R9 start follows last permit", wr_start, last_ok);
      chk(!arr_permit, "R11 permit cleared on deselect", arr_permit, 0);
      if (last_ok) begin
        run_busy(1'b0);
        chk(status[1] == 1'b0, "R10 latch cleared after cycle", status[1], 0);
      end else begin
        wel_clr = 1'b1; tick; wel_clr = 1'b0;
        chk(status[1] == 1'b0, "R10 latch cleared by request", status[1], 0);
      end
    end

    // R9: ignored data bits
    write_sr(8'hFF);
    chk(status == 8'hFC, "R9 only lock and code written", status, 8'hFC);
    write_sr(8'h80);
    chk(status == 8'hE0, "R9 lock set code cleared", status, 8'hE0);

    // R4 R5 R6: lock table with lock bit set
    for (int w = 0; w < 2; w++) begin
      for (int p = 0; p < 2; p++) begin
        if (w == 1) wren;
        wprot_n = p[0];
        cs_n = 1'b0; sr_req = 1'b1; sr_wdata = 8'h80; tick; sr_req = 1'b0;
        chk(sr_permit == (w == 1 && p == 1), "R6 status lock table", sr_permit, (w == 1 && p == 1));
        arr_req = 1'b1; arr_addr = 11'h123; tick; arr_req = 1'b0;
        chk(arr_permit == (w == 1), "R6 array still writable", arr_permit, (w == 1));
        cs_n = 1'b1; tick;
        chk(wr_start == (w == 1), "R9 start for table", wr_start, (w == 1));
        wprot_n = 1'b1;
        if (w == 1) run_busy(1'b0);
      end
    end

    // R5: lock bit clear, pin low still allows status write
    write_sr(8'h00);
    wren; wprot_n = 1'b0;
    cs_n = 1'b0; sr_req = 1'b1; sr_wdata = 8'h0C; tick; sr_req = 1'b0;
    chk(sr_permit == 1'b1, "R5 pin ignored when unlocked", sr_permit, 1);
    cs_n = 1'b1; tick; run_busy(1'b0); wprot_n = 1'b1;
    chk(status == 8'h6C, "R5 unlocked write committed", status, 8'h6C);

    // R7: pin drop cancels an open status write
    write_sr(8'h80);
    wren;
    cs_n = 1'b0; sr_req = 1'b1; sr_wdata = 8'h94; tick; sr_req = 1'b0;
    chk(sr_permit == 1'b1, "R7 permit before drop", sr_permit, 1);
    wprot_n = 1'b0; tick;
    chk(sr_permit == 1'b0, "R7 permit cancelled", sr_permit, 0);
    cs_n = 1'b1; tick;
    chk(wr_start == 1'b0, "R7 no start after cancel", wr_start, 0);
    tick;
    chk(status == 8'hE2, "R7 register unchanged", status, 8'hE2);
    wprot_n = 1'b1;
    wel_clr = 1'b1; tick; wel_clr = 1'b0;

    // R8: pin drop after start has no effect
    wren;
    cs_n = 1'b0; sr_req = 1'b1; sr_wdata = 8'h98; tick; sr_req = 1'b0;
    cs_n = 1'b1; tick;
    chk(wr_start == 1'b1, "R8 start issued", wr_start, 1);
    run_busy(1'b1);
    chk(status == 8'hF8, "R8 write kept after pin drop", status, 8'hF8);
    wprot_n = 1'b1;

    // R11 R1: busy refusal and ready bit
    wren;
    busy = 1'b1; tick;
    chk(status[0] == 1'b1, "R1 ready bit shows busy", status[0], 1);
    cs_n = 1'b0; arr_req = 1'b1; arr_addr = 11'h400; tick;
    chk(arr_permit == 1'b0, "R11 refused while busy", arr_permit, 0);
    busy = 1'b0; tick;
    chk(arr_permit == 1'b1, "R11 granted when idle", arr_permit, 1);
    arr_req = 1'b0; cs_n = 1'b1; tick;
    chk(arr_permit == 1'b0 && wr_start == 1'b1, "R11 deselect clears permit", {arr_permit, wr_start}, 1);
    run_busy(1'b0);
    chk(status[1] == 1'b0, "R10 latch auto clear", status[1], 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule